// File: doc/BRIEF.md
# Receive/Transmit FIFO Threshold and Automatic Flow Controller

This block sits beside the two 64-character FIFOs of a serial port. It never touches the FIFO storage. It reads each FIFO's fill level as a counter and holds a small set of threshold fields, which a host writes through a narrow configuration strobe. From these it produces a receive-data interrupt request and a transmit-space interrupt request. Under automatic flow control it also drives the request-to-send line, and it gates the transmitter from the clear-to-send pin.

Each direction has two ways to set its interrupt threshold. A 2-bit coarse code picks one of four fixed levels. A 4-bit fine field gives the level directly in steps of four characters, and it takes over whenever it is nonzero. Request-to-send uses hysteresis between a halt threshold and a lower resume threshold. This way the far end is throttled before the receive FIFO overflows, and it is released only after the FIFO has drained well below that point.

Top module: `uart_fifo_flow`

## Requirements
- R1: After reset, `rts_o` and `tx_allowed` are 1 and both interrupt requests are 0 (enables low). The fine fields reset to RX 4 and TX 14, halt to 14, resume to 8, and both coarse codes to 0.
- R2: `rx_irq` is 1 exactly when `rx_irq_en` is 1 and `rx_level` >= the receive threshold. With a nonzero RX fine field, the threshold is 4 × field. Trigger-register write (`cfg_target`=1): RX fine in `cfg_data[7:4]`, TX fine in `cfg_data[3:0]`.
- R3: When the RX fine field is 0, the receive threshold comes from the RX coarse code: 0→8, 1→16, 2→56, 3→60. FIFO-control write (`cfg_target`=0): RX code in `cfg_data[7:6]`.
- R4: `tx_irq` is 1 exactly when `tx_irq_en` is 1 and the free space (64 − `tx_level`) >= the transmit threshold. That threshold is 4 × TX fine field when the field is nonzero. When it is 0, the TX coarse code gives 0→8, 1→16, 2→32, 3→56.
- R5: A FIFO-control write updates the TX coarse code (`cfg_data[5:4]`) only while `enh_en` is 1. The RX code is updated regardless.
- R6: With `auto_rts_en`=1, `rts_o` goes to 0 when `rx_level` > 4 × halt field. Flow-threshold write (`cfg_target`=2): resume in `cfg_data[7:4]`, halt in `cfg_data[3:0]`.
- R7: With `auto_rts_en`=1, `rts_o` returns to 1 when `rx_level` < 4 × resume field. At levels between the two thresholds it keeps its previous value.
- R8: With `auto_rts_en`=0, `rts_o` is 1 regardless of `rx_level`.
- R9: A FIFO-control write with `cfg_data[1]`=1 (receive FIFO reset) sets `rts_o` to 1 on the following cycle, even when the level is above the halt threshold.
- R10: `tx_allowed` is 0 when `auto_cts_en`=1 and `cts_i`=0, and 1 otherwise.
- R11: All outputs are registered. A change of level, pin or enable shows up one clock later, and a configuration write shows up on the interrupt outputs two clocks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_target | input | 2 | Write target: 0 FIFO control, 1 trigger levels, 2 flow thresholds, 3 none |
| cfg_data | input | 8 | Write data |
| enh_en | input | 1 | Enhanced-function enable; unlocks the TX coarse code |
| auto_rts_en | input | 1 | Automatic request-to-send enable |
| auto_cts_en | input | 1 | Automatic clear-to-send gating enable |
| rx_irq_en | input | 1 | Receive-data interrupt enable |
| tx_irq_en | input | 1 | Transmit-space interrupt enable |
| rx_level | input | 7 | Receive FIFO fill level, 0..64 |
| tx_level | input | 7 | Transmit FIFO fill level, 0..64 |
| cts_i | input | 1 | Clear-to-send, 1 = asserted |
| rx_irq | output | 1 | Receive-data interrupt request |
| tx_irq | output | 1 | Transmit-space interrupt request |
| rts_o | output | 1 | Request-to-send, 1 = asserted |
| tx_allowed | output | 1 | Transmitter may take the next character |

## Verification
The assertions assume that both level counters stay within 0..64. They also assume that a FIFO reset is signalled only through a FIFO-control write and never by a separate pin. The stimulus keeps to these limits: it drives levels only from the fixed in-range values of each scenario, and it issues every write as a single-cycle strobe from a task. The hysteresis checks also assume that the halt threshold is at or above the resume threshold. The bench programs only such pairs.

// File: rtl/uft_pkg.sv
package uft_pkg;
    typedef enum logic [1:0] {
        TGT_FIFOCTL = 2'd0,
        TGT_TRIG    = 2'd1,
        TGT_FLOW    = 2'd2,
        TGT_NONE    = 2'd3
    } cfg_tgt_e;

    typedef struct packed {
        logic [1:0] rx_code;
        logic [1:0] tx_code;
        logic [3:0] rx_fine;
        logic [3:0] tx_fine;
        logic [3:0] halt;
        logic [3:0] resume;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{
        rx_code: 2'd0, tx_code: 2'd0,
        rx_fine: 4'd4, tx_fine: 4'd14,
        halt:    4'd14, resume: 4'd8
    };
endpackage

// File: rtl/uft_cfg.sv
module uft_cfg
    import uft_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [1:0] target,
    input  logic [7:0] data,
    input  logic       enh_en,
    output cfg_t       cfg,
    output logic       rx_flush
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr) begin
            unique case (cfg_tgt_e'(target))
                TGT_FIFOCTL: begin
                    cfg_d.rx_code = data[7:6];
                    if (enh_en) cfg_d.tx_code = data[5:4];
                end
                TGT_TRIG: begin
                    cfg_d.rx_fine = data[7:4];
                    cfg_d.tx_fine = data[3:0];
                end
                TGT_FLOW: begin
                    cfg_d.resume = data[7:4];
                    cfg_d.halt   = data[3:0];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= CFG_RESET;
        else        cfg_q <= cfg_d;
    end

    assign cfg      = cfg_q;
    assign rx_flush = wr && (cfg_tgt_e'(target) == TGT_FIFOCTL) && data[1];

    assert_tx_code_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && cfg_tgt_e'(target) == TGT_FIFOCTL && !enh_en) |=> $stable(cfg_q.tx_code));
    assert_rx_code_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && cfg_tgt_e'(target) == TGT_FIFOCTL) |=> (cfg_q.rx_code == $past(data[7:6])));
endmodule

// File: rtl/uft_trig.sv
module uft_trig #(
    parameter int DEPTH = 64,
    parameter bit IS_RX = 1'b1,
    localparam int LVL_W = $clog2(DEPTH) + 1
) (
    input  logic [1:0]       code,
    input  logic [3:0]       fine,
    output logic [LVL_W-1:0] level
);
    localparam int STEP = DEPTH / 16;
    logic [LVL_W-1:0] coarse;

    generate
        if (IS_RX) begin : g_rx_table
            always_comb begin
                unique case (code)
                    2'd0:    coarse = LVL_W'(DEPTH / 8);
                    2'd1:    coarse = LVL_W'(DEPTH / 4);
                    2'd2:    coarse = LVL_W'(DEPTH - 8);
                    default: coarse = LVL_W'(DEPTH - 4);
                endcase
            end
        end else begin : g_tx_table
            always_comb begin
                unique case (code)
                    2'd0:    coarse = LVL_W'(DEPTH / 8);
                    2'd1:    coarse = LVL_W'(DEPTH / 4);
                    2'd2:    coarse = LVL_W'(DEPTH / 2);
                    default: coarse = LVL_W'(DEPTH - 8);
                endcase
            end
        end
    endgenerate

    always_comb begin
        if (fine != 4'd0) level = LVL_W'(int'(fine) * STEP);
        else              level = coarse;
    end
endmodule

// File: rtl/uft_rts.sv
module uft_rts #(
    parameter int LVL_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             auto_en,
    input  logic             flush,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] halt_lvl,
    input  logic [LVL_W-1:0] resume_lvl,
    output logic             rts
);
    logic rts_d, rts_q;

    always_comb begin
        rts_d = rts_q;
        if (flush || !auto_en)         rts_d = 1'b1;
        else if (rx_level > halt_lvl)  rts_d = 1'b0;
        else if (rx_level < resume_lvl) rts_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rts_q <= 1'b1;
        else        rts_q <= rts_d;
    end

    assign rts = rts_q;

    assert_rts_halt_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && !flush && rx_level > halt_lvl) |=> !rts_q);
    assert_rts_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && !flush && rx_level <= halt_lvl && rx_level >= resume_lvl) |=> $stable(rts_q));
    assert_rts_manual_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_en |=> rts_q);
    assert_rts_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> rts_q);
endmodule

// File: rtl/uart_fifo_flow.sv
module uart_fifo_flow
    import uft_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int LVL_W = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [1:0]       cfg_target,
    input  logic [7:0]       cfg_data,
    input  logic             enh_en,
    input  logic             auto_rts_en,
    input  logic             auto_cts_en,
    input  logic             rx_irq_en,
    input  logic             tx_irq_en,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] tx_level,
    input  logic             cts_i,
    output logic             rx_irq,
    output logic             tx_irq,
    output logic             rts_o,
    output logic             tx_allowed
);
    localparam int STEP = DEPTH / 16;

    typedef struct packed {
        logic rx_irq;
        logic tx_irq;
        logic tx_ok;
    } out_t;

    cfg_t             cfg;
    logic             rx_flush;
    logic [LVL_W-1:0] rx_trig, tx_trig, halt_lvl, resume_lvl, tx_free;
    out_t             out_d, out_q;

    uft_cfg u_cfg (
        .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .target(cfg_target),
        .data(cfg_data), .enh_en(enh_en), .cfg(cfg), .rx_flush(rx_flush)
    );

    uft_trig #(.DEPTH(DEPTH), .IS_RX(1'b1)) u_rx_trig (
        .code(cfg.rx_code), .fine(cfg.rx_fine), .level(rx_trig)
    );
    uft_trig #(.DEPTH(DEPTH), .IS_RX(1'b0)) u_tx_trig (
        .code(cfg.tx_code), .fine(cfg.tx_fine), .level(tx_trig)
    );

    assign halt_lvl   = LVL_W'(int'(cfg.halt) * STEP);
    assign resume_lvl = LVL_W'(int'(cfg.resume) * STEP);
    assign tx_free    = LVL_W'(DEPTH) - tx_level;

    uft_rts #(.LVL_W(LVL_W)) u_rts (
        .clk(clk), .rst_n(rst_n), .auto_en(auto_rts_en), .flush(rx_flush),
        .rx_level(rx_level), .halt_lvl(halt_lvl), .resume_lvl(resume_lvl),
        .rts(rts_o)
    );

    always_comb begin
        out_d.rx_irq = rx_irq_en && (rx_level >= rx_trig);
        out_d.tx_irq = tx_irq_en && (tx_free >= tx_trig);
        out_d.tx_ok  = !auto_cts_en || cts_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '{rx_irq: 1'b0, tx_irq: 1'b0, tx_ok: 1'b1};
        else        out_q <= out_d;
    end

    assign rx_irq     = out_q.rx_irq;
    assign tx_irq     = out_q.tx_irq;
    assign tx_allowed = out_q.tx_ok;

    assert_level_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level <= LVL_W'(DEPTH)) && (tx_level <= LVL_W'(DEPTH)));
    assert_rx_irq_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_irq_en |=> !rx_irq);
    assert_tx_irq_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_irq_en |=> !tx_irq);
    assert_cts_block_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_cts_en && !cts_i) |=> !tx_allowed);
    assert_cts_free_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_cts_en |=> tx_allowed);
endmodule

// File: tb/uart_fifo_flow_bench.sv
module uart_fifo_flow_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [1:0] cfg_target = 2'd3;
    logic [7:0] cfg_data = 8'd0;
    logic       enh_en = 1'b0, auto_rts_en = 1'b0, auto_cts_en = 1'b0;
    logic       rx_irq_en = 1'b0, tx_irq_en = 1'b0;
    logic [6:0] rx_level = 7'd0, tx_level = 7'd0;
    logic       cts_i = 1'b1;
    logic       rx_irq, tx_irq, rts_o, tx_allowed;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    uart_fifo_flow u_uart_fifo_flow (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_target(cfg_target),
        .cfg_data(cfg_data), .enh_en(enh_en), .auto_rts_en(auto_rts_en),
        .auto_cts_en(auto_cts_en), .rx_irq_en(rx_irq_en), .tx_irq_en(tx_irq_en),
        .rx_level(rx_level), .tx_level(tx_level), .cts_i(cts_i),
        .rx_irq(rx_irq), .tx_irq(tx_irq), .rts_o(rts_o), .tx_allowed(tx_allowed)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] tgt, input logic [7:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_target = tgt; cfg_data = d;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_target = 2'd3;
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    function automatic int rx_coarse(input int c);
        case (c) 0: return 8; 1: return 16; 2: return 56; default: return 60; endcase
    endfunction

    task automatic t_reset();
        check("R1 rts after reset", rts_o, 1);
        check("R1 tx_allowed after reset", tx_allowed, 1);
        check("R1 rx_irq after reset", rx_irq, 0);
        check("R1 tx_irq after reset", tx_irq, 0);
    endtask

    task automatic t_rx_fine();
        rx_irq_en = 1'b1;
        rx_level = 7'd15; settle(); check("R2 default rx 15<16", rx_irq, 0);
        rx_level = 7'd16; settle(); check("R2 default rx 16", rx_irq, 1);
        wr(2'd1, {4'd10, 4'd14});
        rx_level = 7'd39; settle(); check("R2 fine 40 at 39", rx_irq, 0);
        rx_level = 7'd40; settle(); check("R2 fine 40 at 40", rx_irq, 1);
        rx_irq_en = 1'b0; settle(); check("R2 disabled", rx_irq, 0);
        rx_irq_en = 1'b1;
    endtask

    task automatic t_rx_coarse();
        wr(2'd1, 8'h0E);
        for (int c = 0; c < 4; c++) begin
            wr(2'd0, 8'(c << 6));
            rx_level = 7'(rx_coarse(c) - 1); settle();
            check($sformatf("R3 code %0d below", c), rx_irq, 0);
            rx_level = 7'(rx_coarse(c)); settle();
            check($sformatf("R3 code %0d at", c), rx_irq, 1);
        end
        rx_irq_en = 1'b0; rx_level = 7'd0;
    endtask

    task automatic t_tx_space();
        tx_irq_en = 1'b1;
        tx_level = 7'd8; settle(); check("R4 default free 56", tx_irq, 1);
        tx_level = 7'd9; settle(); check("R4 default free 55", tx_irq, 0);
        wr(2'd1, 8'h00);
        tx_level = 7'd56; settle(); check("R4 coarse0 free 8", tx_irq, 1);
        tx_level = 7'd57; settle(); check("R4 coarse0 free 7", tx_irq, 0);
    endtask

    task automatic t_enh_gate();
        tx_level = 7'd54;
        enh_en = 1'b0; wr(2'd0, 8'h20); settle();
        check("R5 tx code locked", tx_irq, 1);
        enh_en = 1'b1; wr(2'd0, 8'h20); settle();
        check("R5 tx code 32 unlocked", tx_irq, 0);
        tx_level = 7'd32; settle(); check("R4 coarse2 free 32", tx_irq, 1);
        wr(2'd0, 8'h30); settle(); check("R4 coarse3 free 32<56", tx_irq, 0);
        enh_en = 1'b0; tx_irq_en = 1'b0; tx_level = 7'd0;
    endtask

    task automatic t_rts();
        auto_rts_en = 1'b1;
        rx_level = 7'd56; settle(); check("R6 at halt", rts_o, 1);
        rx_level = 7'd57; settle(); check("R6 above halt", rts_o, 0);
        rx_level = 7'd40; settle(); check("R7 hold low", rts_o, 0);
        rx_level = 7'd32; settle(); check("R7 at resume", rts_o, 0);
        rx_level = 7'd31; settle(); check("R7 below resume", rts_o, 1);
        rx_level = 7'd40; settle(); check("R7 hold high", rts_o, 1);
        wr(2'd2, {4'd2, 4'd4});
        rx_level = 7'd17; settle(); check("R6 new halt 16", rts_o, 0);
        rx_level = 7'd8;  settle(); check("R7 new resume hold", rts_o, 0);
        rx_level = 7'd7;  settle(); check("R7 new resume 8", rts_o, 1);
    endtask

    task automatic t_flush();
        rx_level = 7'd60; settle(); check("R9 pre-flush low", rts_o, 0);
        wr(2'd0, 8'h02);
        check("R9 flush forces rts", rts_o, 1);
        @(negedge clk); check("R11 reacts one clock later", rts_o, 0);
        auto_rts_en = 1'b0; settle(); check("R8 manual rts", rts_o, 1);
        rx_level = 7'd0;
    endtask

    task automatic t_cts();
        auto_cts_en = 1'b1; cts_i = 1'b0;
        @(negedge clk); check("R10 blocked (R11 one clock)", tx_allowed, 0);
        cts_i = 1'b1; settle(); check("R10 cts asserted", tx_allowed, 1);
        auto_cts_en = 1'b0; cts_i = 1'b0; settle(); check("R10 auto off", tx_allowed, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rx_fine();
        t_rx_coarse();
        t_tx_space();
        t_enh_gate();
        t_rts();
        t_flush();
        t_cts();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule